// File: doc/BRIEF.md
# Broadcast Strobe Transmitter

This block is the only driver of a 16-bit address bus that several receivers watch at once. There is no acknowledge line. The only control is an active-low data-valid strobe, and every receiver captures the bus while that strobe is low. Because no receiver answers, the transmitter alone must keep the timing correct. It places each word on the bus before the strobe falls. It keeps the strobe low for a bounded number of cycles. It keeps the word unchanged after the strobe rises, and it leaves a short quiet gap before the next word is allowed onto the bus.

Words arrive on a valid/ready handshake. The block raises ready only while it is idle and the programmed strobe width is legal. The setup, hold and gap lengths are parameters counted in clock cycles. The strobe width comes from a configuration input, and the block captures it when it accepts a word. With a 10 ns clock, the legal width window of 19 to 26 cycles covers a low pulse of 190 to 260 ns, and a width of 22 cycles sits near the middle of that window. Any width outside the window stops the block from accepting words.

Top module: `bc_strobe_tx`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `bus_dv_n` is 1 and `bus_data` is 0. `in_ready` is 1 when `cfg_width` is legal.
- R2: `in_ready` is 1 only when the block is idle. A word is accepted at a rising edge where both `in_valid` and `in_ready` are 1. At that same edge `bus_data` takes the word and `in_ready` drops to 0.
- R3: After a word is accepted, `bus_dv_n` stays 1 for exactly SETUP_CYC cycles with the new word on `bus_data`, and then it falls.
- R4: `bus_dv_n` stays 0 for exactly the number of cycles given by the `cfg_width` value captured at acceptance.
- R5: `bus_data` does not change while `bus_dv_n` is 0 or during the hold and gap that follow. Changes on `in_data` during that time have no effect.
- R6: After `bus_dv_n` rises, exactly HOLD_CYC + GAP_CYC cycles pass with the strobe high before `in_ready` returns to 1.
- R7: When `cfg_width` is below W_MIN (19) or above W_MAX (26), `in_ready` stays 0 and no strobe is issued, even while `in_valid` is 1. `in_ready` returns as soon as the width is legal again.
- R8: A change of `cfg_width` after acceptance does not alter the strobe width of the word already accepted.
- R9: While idle with `in_valid` at 0, `bus_dv_n` stays 1 and `bus_data` keeps the last word, whatever `in_data` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_data | input | DATA_W | Word to broadcast |
| in_ready | output | 1 | The block will take the offered word at the next edge |
| cfg_width | input | CNT_W | Strobe low width in cycles, legal from W_MIN to W_MAX |
| bus_data | output | DATA_W | Registered shared address bus |
| bus_dv_n | output | 1 | Active-low data-valid strobe, idles high |

## Verification
The bench builds the block with SETUP_CYC=2, HOLD_CYC=3 and GAP_CYC=2, and keeps the window at 19 to 26. Because the hold and the setup differ in length, a phase that is swapped or miscounted shows up as a wrong count. Random widths over the whole legal window, including both edges, check that the captured width and the pulse length agree. Directed runs at 18, 27 and 0 check the refusal to start. Changing `in_data` and `cfg_width` in the middle of a transfer checks that the bus word and the pulse width cannot be disturbed once the strobe sequence has begun.

// File: rtl/bc_tx_pkg.sv
// Shared types for the broadcast strobe transmitter.
package bc_tx_pkg;
    // Phases of one broadcast, in the order they occur.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_GAP    = 3'd4
    } bc_state_e;
endpackage

// File: rtl/bc_width_check.sv
// Range guard for the programmed strobe width.
// Purely combinational. It assumes W_MIN <= W_MAX and that both fit in CNT_W bits.
module bc_width_check #(
    parameter int CNT_W = 8,
    parameter int W_MIN = 19,
    parameter int W_MAX = 26
) (
    input  logic [CNT_W-1:0] width,
    output logic             width_ok
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(W_MIN);
    localparam logic [CNT_W-1:0] HI = CNT_W'(W_MAX);

    // Flag a width that lies inside the legal window.
    always_comb begin
        width_ok = (width >= LO) && (width <= HI);
    end
endmodule

// File: rtl/bc_phase_timer.sv
// Down counter shared by all timed phases.
// A load sets the count to (length - 1). `expired` goes high when the count
// reaches zero, which marks the last cycle of the current phase.
// It assumes each phase length is at least 1.
module bc_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count_q;

    // Load a new phase length, or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    // Report the final cycle of the phase.
    always_comb begin
        expired = (count_q == '0);
    end
endmodule

// File: rtl/bc_tx_sequencer.sv
// Phase sequencer. It walks idle -> setup -> strobe -> hold -> gap -> idle.
// It captures the word and the strobe width at acceptance and drives the
// registered bus outputs. The strobe flop is loaded from the next state so
// that the strobe edges line up with the phase changes.
// It assumes SETUP_CYC, HOLD_CYC and GAP_CYC are at least 1.
module bc_tx_sequencer
    import bc_tx_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 2,
    parameter int GAP_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CNT_W-1:0]  cfg_width,
    input  logic              width_ok,
    input  logic              timer_expired,
    output logic              timer_load,
    output logic [CNT_W-1:0]  timer_val,
    output logic              in_ready,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_dv_n
);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);

    bc_state_e        state_q, state_d;
    logic [CNT_W-1:0] width_q;
    logic             accept;

    // Handshake: ready only while idle with a legal width.
    always_comb begin
        in_ready = (state_q == ST_IDLE) && width_ok;
        accept   = in_valid && in_ready;
    end

    // Next-phase choice and timer reload at each phase boundary.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                state_d    = ST_SETUP;
                timer_load = 1'b1;
                timer_val  = SETUP_LD;
            end
            ST_SETUP: if (timer_expired) begin
                state_d    = ST_STROBE;
                timer_load = 1'b1;
                timer_val  = width_q - CNT_W'(1);
            end
            ST_STROBE: if (timer_expired) begin
                state_d    = ST_HOLD;
                timer_load = 1'b1;
                timer_val  = HOLD_LD;
            end
            ST_HOLD: if (timer_expired) begin
                state_d    = ST_GAP;
                timer_load = 1'b1;
                timer_val  = GAP_LD;
            end
            ST_GAP: if (timer_expired) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register and registered strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bus_dv_n <= 1'b1;
        end else begin
            state_q  <= state_d;
            bus_dv_n <= (state_d != ST_STROBE);
        end
    end

    // Capture the word and its width at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_data <= '0;
            width_q  <= '0;
        end else if (accept) begin
            bus_data <= in_data;
            width_q  <= cfg_width;
        end
    end
endmodule

// File: rtl/bc_strobe_tx.sv
// Broadcast strobe transmitter top level.
// One sender drives a shared data bus, and an active-low data-valid strobe
// marks each word. No acknowledge exists, so setup, strobe width, hold and
// an idle gap are all enforced here. It assumes that the receivers capture
// the bus while the strobe is low.
module bc_strobe_tx #(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 2,
    parameter int GAP_CYC   = 2,
    parameter int W_MIN     = 19,
    parameter int W_MAX     = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic [CNT_W-1:0]  cfg_width,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_dv_n
);
    logic             width_ok;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_expired;

    bc_width_check #(.CNT_W(CNT_W), .W_MIN(W_MIN), .W_MAX(W_MAX)) u_wchk (
        .width    (cfg_width),
        .width_ok (width_ok)
    );

    bc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    bc_tx_sequencer #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC),
        .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .cfg_width     (cfg_width),
        .width_ok      (width_ok),
        .timer_expired (timer_expired),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .in_ready      (in_ready),
        .bus_data      (bus_data),
        .bus_dv_n      (bus_dv_n)
    );
endmodule

// File: rtl/bc_strobe_tx_checker.sv
// Timing checker for the broadcast strobe transmitter, bound to the top.
// A local counter measures each low pulse, so no property needs a deep $past.
module bc_strobe_tx_checker #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int W_MIN  = 19,
    parameter int W_MAX  = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_ready,
    input logic [CNT_W-1:0]  cfg_width,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_dv_n
);
    logic [CNT_W-1:0] low_cnt;

    // Count the cycles of the current low pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        low_cnt <= '0;
        else if (bus_dv_n) low_cnt <= '0;
        else               low_cnt <= low_cnt + CNT_W'(1);
    end

    AST_READY_ONLY_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bus_dv_n); // R2
    AST_ACCEPT_LOADS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (bus_dv_n && !in_ready && bus_data == $past(in_data))); // R2
    AST_SETUP_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_dv_n) |-> $stable(bus_data)); // R3
    AST_PULSE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_dv_n) |-> (low_cnt >= CNT_W'(W_MIN) && low_cnt <= CNT_W'(W_MAX))); // R4
    AST_DATA_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_dv_n && $past(!bus_dv_n)) |-> $stable(bus_data)); // R5
    AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_dv_n) |-> (!in_ready && $stable(bus_data))); // R6
    AST_BAD_WIDTH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_width < CNT_W'(W_MIN) || cfg_width > CNT_W'(W_MAX)) |-> !in_ready); // R7
endmodule

bind bc_strobe_tx bc_strobe_tx_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .W_MIN(W_MIN), .W_MAX(W_MAX)
) u_bc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .cfg_width (cfg_width),
    .bus_data  (bus_data),
    .bus_dv_n  (bus_dv_n)
);

// File: tb/bc_strobe_tx_test.sv
module bc_strobe_tx_test;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int SETUP = 2;
    localparam int HOLD  = 3;
    localparam int GAP   = 2;
    localparam int WMIN  = 19;
    localparam int WMAX  = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic [CW-1:0] cfg_width = 8'd22;
    logic [DW-1:0] bus_data;
    logic          bus_dv_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bc_strobe_tx #(
        .DATA_W(DW), .CNT_W(CW), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
        .GAP_CYC(GAP), .W_MIN(WMIN), .W_MAX(WMAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cfg_width(cfg_width), .bus_data(bus_data),
        .bus_dv_n(bus_dv_n)
    );

    // Expected values, taken from the requirements.
    function automatic int exp_setup();
        return SETUP;
    endfunction
    function automatic int exp_low(input int w);
        return w;
    endfunction
    function automatic int exp_tail();
        return HOLD + GAP;
    endfunction
    function automatic bit legal(input int w);
        return (w >= WMIN) && (w <= WMAX);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Send one word at width w, then measure every phase at the ports.
    task automatic send(input logic [DW-1:0] d, input int w);
        int n;
        bit data_ok;
        cfg_width = CW'(w);
        in_data   = d;
        in_valid  = 1'b1;
        n = 0;
        while (!in_ready && n < 200) begin @(negedge clk); n++; end
        @(negedge clk);
        // first setup cycle: the word is on the bus and ready has dropped (R2)
        chk(bus_data == d && !in_ready, "R2 accept", int'(bus_data), int'(d));
        in_valid  = 1'b0;
        in_data   = ~d;
        cfg_width = CW'(legal(w + 3) ? w + 3 : w - 3);
        n = 0; data_ok = 1;
        while (bus_dv_n && n < 100) begin
            if (bus_data !== d) data_ok = 0;
            n++; @(negedge clk);
        end
        chk(n == exp_setup() && data_ok, "R3 setup", n, exp_setup());
        n = 0; data_ok = 1;
        while (!bus_dv_n && n < 100) begin
            if (bus_data !== d) data_ok = 0;
            n++; @(negedge clk);
        end
        chk(n == exp_low(w), "R4 R8 strobe width", n, exp_low(w));
        chk(data_ok, "R5 data stable low", int'(bus_data), int'(d));
        n = 0; data_ok = 1;
        while (!in_ready && n < 100) begin
            if (bus_data !== d || !bus_dv_n) data_ok = 0;
            n++; @(negedge clk);
        end
        chk(n == exp_tail(), "R6 hold+gap", n, exp_tail());
        chk(data_ok, "R5 data stable hold", int'(bus_data), int'(d));
    endtask

    task automatic bad_width(input int w);
        bit ok;
        cfg_width = CW'(w);
        in_valid  = 1'b1;
        in_data   = 16'hBEEF;
        ok = 1;
        repeat (10) begin
            @(negedge clk);
            if (in_ready || !bus_dv_n) ok = 0;
        end
        chk(ok, "R7 illegal width blocks", w, 0);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [DW-1:0] last;
        bit ok;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(bus_dv_n === 1'b1 && bus_data === '0, "R1 in reset", int'(bus_dv_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_dv_n === 1'b1 && bus_data === '0 && in_ready === 1'b1,
            "R1 after reset", int'(in_ready), 1);

        send(16'hA5C3, 22);
        send(16'h0001, WMIN);
        send(16'hFFFF, WMAX);

        bad_width(WMIN - 1);
        bad_width(WMAX + 1);
        bad_width(0);
        cfg_width = 8'd22;
        #1;
        chk(in_ready === 1'b1, "R7 ready back on legal width", int'(in_ready), 1);

        // R9: idle with valid low keeps the bus quiet and unchanged
        last = bus_data;
        ok = 1;
        for (int i = 0; i < 8; i++) begin
            in_data = DW'($urandom);
            @(negedge clk);
            if (!bus_dv_n || bus_data !== last) ok = 0;
        end
        chk(ok, "R9 idle no effect", int'(bus_data), int'(last));

        for (int k = 0; k < 40; k++) begin
            send(DW'($urandom), WMIN + int'($urandom % (WMAX - WMIN + 1)));
        end

        done = 1;
        summary();
    end
endmodule